// File: doc/BRIEF.md
# Three-Pulse Position and Phase Package Modulator

This block turns one 8-bit symbol into a package of up to three pulses. The pulses are timed on a fast oscillator clock that is gated on only while a package is sent. Each cycle it decides whether the oscillator edge goes on to the pulse generator or is swallowed, so the gaps between pulses are whole oscillator periods. It also gives each passed pulse a polarity bit for a bi-phasic pulse generator.

The package is two chained transmitted-reference pairs. The first pulse is a reference for the second, and the second is a reference for the third. The gap to the second pulse comes from a 3-bit delay field. The gap to the third pulse comes from a 2-bit delay field, in which one code drops the third pulse. A 3-bit phase word sets the three polarities. The package pattern is loaded into a shift register when the symbol strobe rises. The register is then shifted once per oscillator cycle. The oscillator enable drops once the register holds no more pulses.

Top module: `pulse_pack_mod`

## Requirements
- R1: After reset, pulseGate, pulsePol, oscEn, busy, done and overrun are all 0.
- R2: The symbol fields are: first-gap code in symbol[7:5], second-gap code in symbol[4:3], phase word in symbol[2:0]. The first clock edge that samples symValid high after it was low loads the package. In the cycle after that edge, pulseGate is 1 (first pulse).
- R3: With first-gap code a, the second pulse is passed a+1 cycles after the first (cycle a+1). Every cycle between the first and second pulses has pulseGate 0.
- R4: With second-gap code b of 1, 2 or 3, the third pulse is passed b cycles after the second. The cycles between them have pulseGate 0.
- R5: With second-gap code 0, no third pulse is passed, and symbol[0] has no effect on any output.
- R6: On a passed pulse, pulsePol is 1 for +1 and 0 for -1. It equals symbol[2] on the first pulse, symbol[1] on the second and symbol[0] on the third. On swallowed cycles pulsePol is 0.
- R7: busy and oscEn are 1 from the first-pulse cycle through the cycle of the last passed pulse, and 0 otherwise.
- R8: done is 1 for exactly one cycle, the cycle right after the last passed pulse.
- R9: A rising symValid while busy is 1 does not change the running package. It sets overrun, which stays 1 until reset.
- R10: symValid held high starts only one package. A new package needs symValid to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Symbol strobe; a package starts on its rising edge |
| symbol | input | 8 | Symbol: first-gap code, second-gap code, phase word |
| pulseGate | output | 1 | 1 = pass this cycle's edge to the pulse generator |
| pulsePol | output | 1 | Polarity of the passed pulse (1 = +1) |
| oscEn | output | 1 | Oscillator enable |
| busy | output | 1 | Package in progress |
| done | output | 1 | One-cycle strobe after the last pulse |
| overrun | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The main function is driven with all 256 symbols. Each package's gate and polarity sequence is compared cycle by cycle against a model built from the field definitions. This separates off-by-one errors in each gap, swapped phase bits, and a null code that wrongly emits or keeps D0. Sending symbols that differ only in bit 0 while the second gap is null shows that bit has no effect. A strobe raised in the middle of the longest package, and a strobe held high across a package end, separate real edge detection and rejection of a new symbol from a level-triggered restart.

// File: rtl/pulse_pack_pkg.sv
package pulse_pack_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } ctlStrobe_t;
endpackage

// File: rtl/pulse_pack_dp.sv
module pulse_pack_dp
  import pulse_pack_pkg::*;
#(
  parameter int AW = 3,
  parameter int BW = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [AW+BW+2:0]      symbol,
  output logic                  gateBit,
  output logic                  polBit,
  output logic                  tailEmpty
);
  localparam int SYM_W = AW + BW + 3;
  localparam int SR_W  = (2 ** AW) + (2 ** BW);
  localparam int POS_W = $clog2(SR_W);

  logic [AW-1:0]    aCode;
  logic [BW-1:0]    bCode;
  logic [2:0]       phase;
  logic [POS_W-1:0] pos2, pos3;
  logic             thirdOn;
  logic [SR_W-1:0]  patGate, patPol;
  logic [SR_W-1:0]  gateSr, polSr;

  assign aCode   = symbol[SYM_W-1 -: AW];
  assign bCode   = symbol[3 +: BW];
  assign phase   = symbol[2:0];
  assign thirdOn = (bCode != '0);
  assign pos2    = POS_W'(aCode) + POS_W'(1);
  assign pos3    = pos2 + POS_W'(bCode);

  for (genvar g = 0; g < SR_W; g++) begin : g_pat
    localparam logic [POS_W-1:0] IDX = POS_W'(g);
    logic isFirst, isSecond, isThird;
    assign isFirst      = (g == 0);
    assign isSecond     = (IDX == pos2);
    assign isThird      = thirdOn && (IDX == pos3);
    assign patGate[g]   = isFirst | isSecond | isThird;
    assign patPol[g]    = (isFirst & phase[2]) | (isSecond & phase[1]) |
                          (isThird & phase[0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateSr <= '0;
      polSr  <= '0;
    end else if (strobe.load) begin
      gateSr <= patGate;
      polSr  <= patPol;
    end else if (strobe.shift) begin
      gateSr <= gateSr >> 1;
      polSr  <= polSr >> 1;
    end
  end

  assign gateBit   = gateSr[0];
  assign polBit    = polSr[0] & gateSr[0];
  assign tailEmpty = ~|gateSr[SR_W-1:1];
endmodule

// File: rtl/pulse_pack_ctrl.sv
module pulse_pack_ctrl
  import pulse_pack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic       tailEmpty,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       overrun
);
  logic symValidQ, busyQ, doneQ, overrunQ, rise;

  assign rise         = symValid & ~symValidQ;
  assign strobe.load  = rise & ~busyQ;
  assign strobe.shift = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symValidQ <= 1'b0;
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      overrunQ  <= 1'b0;
    end else begin
      symValidQ <= symValid;
      doneQ     <= busyQ & tailEmpty;
      overrunQ  <= overrunQ | (busyQ & rise);
      if (strobe.load)
        busyQ <= 1'b1;
      else if (busyQ && tailEmpty)
        busyQ <= 1'b0;
    end
  end

  assign busy    = busyQ;
  assign done    = doneQ;
  assign overrun = overrunQ;
endmodule

// File: rtl/pulse_pack_mod.sv
module pulse_pack_mod
  import pulse_pack_pkg::*;
#(
  parameter int AW = 3,
  parameter int BW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic [AW+BW+2:0]  symbol,
  output logic              pulseGate,
  output logic              pulsePol,
  output logic              oscEn,
  output logic              busy,
  output logic              done,
  output logic              overrun
);
  ctlStrobe_t strobe;
  logic       tailEmpty;

  pulse_pack_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .tailEmpty(tailEmpty),
    .strobe(strobe), .busy(busy), .done(done), .overrun(overrun)
  );

  pulse_pack_dp #(.AW(AW), .BW(BW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .symbol(symbol),
    .gateBit(pulseGate), .polBit(pulsePol), .tailEmpty(tailEmpty)
  );

  assign oscEn = busy;
endmodule

// File: rtl/pulse_pack_chk.sv
module pulse_pack_chk (
  input logic clk,
  input logic rstN,
  input logic pulseGate,
  input logic pulsePol,
  input logic oscEn,
  input logic busy,
  input logic done,
  input logic overrun
);
  // R2
  first_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> pulseGate);
  // R6
  pol_only_on_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pulseGate |-> !pulsePol);
  // R7
  gate_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseGate |-> (busy && oscEn));
  // R7
  osc_follows_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscEn == busy);
  // R8
  done_after_pkg_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy && !pulseGate));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
endmodule

bind pulse_pack_mod pulse_pack_chk i_chk (
  .clk(clk), .rstN(rstN), .pulseGate(pulseGate), .pulsePol(pulsePol),
  .oscEn(oscEn), .busy(busy), .done(done), .overrun(overrun)
);

// File: tb/test_pulse_pack_mod.sv
module test_pulse_pack_mod;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic [7:0] symbol = '0;
  logic       pulseGate, pulsePol, oscEn, busy, done, overrun;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pulse_pack_mod i_pulse_pack_mod (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symbol(symbol),
    .pulseGate(pulseGate), .pulsePol(pulsePol), .oscEn(oscEn),
    .busy(busy), .done(done), .overrun(overrun)
  );

  task automatic check(input string tag, input string what,
                       input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t",
               tag, what, actual, expected, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    finished = 1'b1;
    $finish;
  endtask

  // Drives one symbol from a low strobe. Checks every cycle up to the done strobe.
  // midStrobeAt >= 0 raises the strobe again at that cycle (R9 scenario).
  task automatic sendSymbol(input logic [7:0] sym, input int midStrobeAt);
    int a, b, p2, p3, last;
    bit expG, expP;
    string gTag;
    a  = int'(sym[7:5]);
    b  = int'(sym[4:3]);
    p2 = a + 1;
    p3 = (b != 0) ? p2 + b : -1;
    last = (b != 0) ? p3 : p2;
    @(negedge clk);
    symValid = 1'b1;
    symbol   = sym;
    @(negedge clk);
    for (int k = 0; k <= last + 1; k++) begin
      expG = (k == 0) || (k == p2) || (k == p3);
      expP = (k == 0) ? sym[2] : (k == p2) ? sym[1] : (k == p3) ? sym[0] : 1'b0;
      gTag = (k == 0) ? "R2" : (k <= p2) ? "R3" : (b == 0) ? "R5" : "R4";
      check(gTag, $sformatf("gate sym=%02h cyc=%0d", sym, k), int'(pulseGate), int'(expG));
      check("R6", $sformatf("pol sym=%02h cyc=%0d", sym, k), int'(pulsePol), int'(expP));
      check("R7", $sformatf("busy sym=%02h cyc=%0d", sym, k), int'(busy), int'(k <= last));
      check("R7", $sformatf("oscEn sym=%02h cyc=%0d", sym, k), int'(oscEn), int'(k <= last));
      check("R8", $sformatf("done sym=%02h cyc=%0d", sym, k), int'(done), int'(k == last + 1));
      if (midStrobeAt >= 0 && k == midStrobeAt + 1)
        check("R9", "overrun after mid-package strobe", int'(overrun), 1);
      if (k == 0) symValid = 1'b0;
      if (k == midStrobeAt) begin
        symValid = 1'b1;
        symbol   = 8'h00;
      end
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "pulseGate", int'(pulseGate), 0);
    check("R1", "pulsePol",  int'(pulsePol), 0);
    check("R1", "oscEn",     int'(oscEn), 0);
    check("R1", "busy",      int'(busy), 0);
    check("R1", "done",      int'(done), 0);
    check("R1", "overrun",   int'(overrun), 0);
  endtask

  task automatic testAllSymbols();
    for (int s = 0; s < 256; s++) sendSymbol(8'(s), -1);
    check("R9", "overrun stays clear without collision", int'(overrun), 0);
  endtask

  // R10: strobe held high starts only one package
  task automatic testHeldStrobe();
    @(negedge clk);
    symValid = 1'b1;
    symbol   = 8'h00;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        check("R10", "busy with held strobe", int'(busy), 0);
        check("R10", "gate with held strobe", int'(pulseGate), 0);
      end
    end
    symValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic testOverrun();
    sendSymbol(8'hFF, 2);
    for (int k = 0; k < 3; k++) begin
      check("R9", "no restart after rejected strobe", int'(busy), 0);
      @(negedge clk);
    end
    symValid = 1'b0;
    @(negedge clk);
    sendSymbol(8'h25, -1);
    check("R9", "overrun sticky after later package", int'(overrun), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllSymbols();
    testHeldStrobe();
    testOverrun();
    summary();
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule